// File: doc/BRIEF.md
# Eight-Channel Doorbell Mailbox

This block connects a host processor to a power-management coprocessor through eight independent doorbell channels. For each channel the host posts a request by raising a pending bit, and it leaves a one-byte request header that the coprocessor reads. The coprocessor finishes a request with a done strobe. To answer, it raises an acknowledge bit together with a one-byte acknowledge header. The host sees a single level interrupt that stays high while any acknowledge bit is set. The host clears those bits by writing ones to a clear register.

The host side is a simple register port. A write takes effect on the clock edge where `host_we` is high. Reads are combinational from `host_addr`. Register indices are word indices. The data bus is `DATA_W` bits wide and carries one bit per channel (bit n is channel n) in its low bits. The request headers sit at eight consecutive indices starting at 0x10, and the acknowledge headers follow at the next eight indices. The control indices are: 0x00 request-set (write), 0x01 request-value (read), 0x02 acknowledge-status (read) and 0x03 acknowledge-clear (write).

The coprocessor's acknowledge input is a valid-only stream of one channel number and one header byte per cycle. The block takes a beat on every cycle where `cp_ack_valid` is high and never applies back-pressure, so it has no ready signal. The done strobes and the request outputs are plain control pins. Before it posts a new request on a channel, the host must read that channel's pending bit as 0. At start-up it should write 0xFF to the clear register.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, every pending bit, acknowledge-status bit, request header and acknowledge header reads 0, and `host_irq` is low.
- R2: A write to index 0x00 sets the pending bit of each channel whose data bit is 1. Channels whose data bit is 0 keep their state. The new value is visible the cycle after the write.
- R3: A high bit of `cp_done` clears that channel's pending bit on the next cycle. If a host set and a done strobe hit the same channel in the same cycle, the bit ends up set.
- R4: Reads of index 0x00 and of index 0x01 both return the eight pending bits in data bits 7:0, with zeros above. The same bits drive `cp_req_pending`.
- R5: A host write to index 0x10+n stores data bits 7:0 as the request header of channel n. That header reads back at the same index and appears on `cp_req_hdr[8n+7:8n]`.
- R6: When `cp_ack_valid` is high, the channel given by `cp_ack_ch` gets its acknowledge-status bit set, and `cp_ack_hdr` is stored as its acknowledge header, readable at index 0x18+n. Index 0x02 returns the status bits in data bits 7:0.
- R7: Writing to index 0x03 clears each status bit whose data bit is 1. Data bits above bit 7 have no effect. A raise in the same cycle on the same channel wins, and the bit stays set.
- R8: `host_irq` is high exactly while at least one acknowledge-status bit is set.
- R9: Host writes to indices 0x01, 0x02 and 0x18 to 0x1F change no state.
- R10: Reads of any index outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register index |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| host_irq | output | 1 | Level interrupt, high while any acknowledge bit is set |
| cp_req_pending | output | NUM_CH | Request-pending bits toward the coprocessor |
| cp_req_hdr | output | NUM_CH*8 | Request header bytes, channel n in byte n |
| cp_done | input | NUM_CH | Per-channel request-done strobes |
| cp_ack_valid | input | 1 | Acknowledge beat valid (always accepted) |
| cp_ack_ch | input | CH_W | Channel of the acknowledge beat |
| cp_ack_hdr | input | 8 | Acknowledge header byte |

## Verification
The cases hardest to reach from the ports are the same-cycle collisions: a host set meeting a done strobe, and a host clear meeting a raise on the same channel. Each needs two independent interfaces to hit one bit on one edge. The bench drives both sides from one task that sets every input for a single cycle, so the collisions are placed exactly. A long stretch of random traffic then produces further collisions, out-of-map writes and writes to read-only indices. Throughout, a behavioural model checks every output on every clock.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned MB_CHANNELS = 8;
  localparam int unsigned MB_HDR_W    = 8;
  localparam int unsigned MB_ADDR_W   = 5;
  localparam int unsigned MB_DATA_W   = 32;

  // register indices; header blocks are contiguous, ack block follows request block
  localparam int unsigned IDX_REQ_SET  = 'h00;
  localparam int unsigned IDX_REQ_VAL  = 'h01;
  localparam int unsigned IDX_ACK_STAT = 'h02;
  localparam int unsigned IDX_ACK_CLR  = 'h03;
  localparam int unsigned IDX_REQ_HDR  = 'h10;
  localparam int unsigned IDX_ACK_HDR  = IDX_REQ_HDR + MB_CHANNELS;
endpackage

// File: rtl/db_host_decode.sv
module db_host_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = MB_CHANNELS,
  parameter int unsigned ADDR_W = MB_ADDR_W,
  parameter int unsigned DATA_W = MB_DATA_W,
  parameter int unsigned HDR_W  = MB_HDR_W
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] set_mask,
  output logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] hdr_we,
  output logic [HDR_W-1:0]  hdr_byte
);
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (we && addr == ADDR_W'(IDX_REQ_SET)) set_mask = wdata[NUM_CH-1:0];
    if (we && addr == ADDR_W'(IDX_ACK_CLR)) clr_mask = wdata[NUM_CH-1:0];
  end

  assign hdr_byte = wdata[HDR_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hdr_sel
    assign hdr_we[g] = we && (addr == ADDR_W'(IDX_REQ_HDR + g));
  end
endmodule

// File: rtl/db_req_bank.sv
module db_req_bank
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = MB_CHANNELS,
  parameter int unsigned HDR_W  = MB_HDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            set_mask,
  input  logic [NUM_CH-1:0]            done_mask,
  input  logic [NUM_CH-1:0]            hdr_we,
  input  logic [HDR_W-1:0]             hdr_byte,
  output logic [NUM_CH-1:0]            pend_q,
  output logic [NUM_CH-1:0][HDR_W-1:0] hdr_q
);
  // set is applied after done so a collision leaves the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~done_mask) | set_mask;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hdr_q[g] <= '0;
      else if (hdr_we[g]) hdr_q[g] <= hdr_byte;
    end
  end
endmodule

// File: rtl/db_ack_bank.sv
module db_ack_bank
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = MB_CHANNELS,
  parameter int unsigned HDR_W  = MB_HDR_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         raise_valid,
  input  logic [CH_W-1:0]              raise_ch,
  input  logic [HDR_W-1:0]             raise_hdr,
  input  logic [NUM_CH-1:0]            clr_mask,
  output logic [NUM_CH-1:0]            stat_q,
  output logic [NUM_CH-1:0][HDR_W-1:0] hdr_q
);
  logic [NUM_CH-1:0] raise_mask;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign raise_mask[g] = raise_valid && (raise_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hdr_q[g] <= '0;
      else if (raise_mask[g]) hdr_q[g] <= raise_hdr;
    end
  end

  // raise applied after clear: an event arriving with a clear is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | raise_mask;
  end
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = MB_CHANNELS,
  parameter int unsigned ADDR_W = MB_ADDR_W,
  parameter int unsigned DATA_W = MB_DATA_W,
  localparam int unsigned HDR_W = MB_HDR_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic                    host_irq,
  output logic [NUM_CH-1:0]       cp_req_pending,
  output logic [NUM_CH*HDR_W-1:0] cp_req_hdr,
  input  logic [NUM_CH-1:0]       cp_done,
  input  logic                    cp_ack_valid,
  input  logic [CH_W-1:0]         cp_ack_ch,
  input  logic [HDR_W-1:0]        cp_ack_hdr
);
  logic [NUM_CH-1:0]            set_mask, clr_mask, rq_hdr_we;
  logic [HDR_W-1:0]             wr_byte;
  logic [NUM_CH-1:0]            pend_q, stat_q;
  logic [NUM_CH-1:0][HDR_W-1:0] rq_hdr_q, ak_hdr_q;

  db_host_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_W(HDR_W)) u_dec (
    .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .set_mask(set_mask), .clr_mask(clr_mask), .hdr_we(rq_hdr_we), .hdr_byte(wr_byte)
  );

  db_req_bank #(.NUM_CH(NUM_CH), .HDR_W(HDR_W)) u_req (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .done_mask(cp_done),
    .hdr_we(rq_hdr_we), .hdr_byte(wr_byte), .pend_q(pend_q), .hdr_q(rq_hdr_q)
  );

  db_ack_bank #(.NUM_CH(NUM_CH), .HDR_W(HDR_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .raise_valid(cp_ack_valid), .raise_ch(cp_ack_ch),
    .raise_hdr(cp_ack_hdr), .clr_mask(clr_mask), .stat_q(stat_q), .hdr_q(ak_hdr_q)
  );

  assign cp_req_pending = pend_q;
  assign cp_req_hdr     = rq_hdr_q;
  assign host_irq       = |stat_q;

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(IDX_REQ_SET) || host_addr == ADDR_W'(IDX_REQ_VAL))
      host_rdata = DATA_W'(pend_q);
    else if (host_addr == ADDR_W'(IDX_ACK_STAT))
      host_rdata = DATA_W'(stat_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (host_addr == ADDR_W'(IDX_REQ_HDR + i)) host_rdata = DATA_W'(rq_hdr_q[i]);
      if (host_addr == ADDR_W'(IDX_ACK_HDR + i)) host_rdata = DATA_W'(ak_hdr_q[i]);
    end
  end
endmodule

// File: rtl/db_mbox_chk.sv
module db_mbox_chk
  import doorbell_pkg::*;
#(
  parameter int unsigned NUM_CH = MB_CHANNELS,
  parameter int unsigned ADDR_W = MB_ADDR_W,
  parameter int unsigned DATA_W = MB_DATA_W,
  parameter int unsigned HDR_W  = MB_HDR_W,
  parameter int unsigned CH_W   = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         host_we,
  input logic [ADDR_W-1:0]            host_addr,
  input logic [DATA_W-1:0]            host_wdata,
  input logic                         host_irq,
  input logic [NUM_CH-1:0]            cp_req_pending,
  input logic [NUM_CH-1:0]            cp_done,
  input logic                         cp_ack_valid,
  input logic [CH_W-1:0]              cp_ack_ch,
  input logic [NUM_CH-1:0]            stat_q,
  input logic [NUM_CH-1:0][HDR_W-1:0] ak_hdr_q
);
  logic [NUM_CH-1:0] w_set, w_clr, w_raise;
  assign w_set   = (host_we && host_addr == ADDR_W'(IDX_REQ_SET)) ? host_wdata[NUM_CH-1:0] : '0;
  assign w_clr   = (host_we && host_addr == ADDR_W'(IDX_ACK_CLR)) ? host_wdata[NUM_CH-1:0] : '0;
  assign w_raise = cp_ack_valid ? (NUM_CH'(1) << cp_ack_ch) : '0;

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_set != '0) |=> ((cp_req_pending & $past(w_set)) == $past(w_set)));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_set == '0 && cp_done == '0) |=> $stable(cp_req_pending));

  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_done & ~w_set) != '0) |=> ((cp_req_pending & $past(cp_done & ~w_set)) == '0));

  assert_raise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_ack_valid |=> stat_q[$past(cp_ack_ch)]);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_clr & ~w_raise) != '0) |=> ((stat_q & $past(w_clr & ~w_raise)) == '0));

  assert_irq_on_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cp_ack_valid |=> host_irq);

  assert_irq_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> ($past(w_clr) != '0));

  assert_ack_hdr_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_ack_valid |=> $stable(ak_hdr_q));
endmodule

bind doorbell_mbox db_mbox_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_W(HDR_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_irq(host_irq), .cp_req_pending(cp_req_pending),
  .cp_done(cp_done), .cp_ack_valid(cp_ack_valid), .cp_ack_ch(cp_ack_ch),
  .stat_q(stat_q), .ak_hdr_q(ak_hdr_q)
);

// File: tb/doorbell_mbox_test.sv
`timescale 1ns/1ps
module doorbell_mbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic [7:0]  cp_req_pending;
  logic [63:0] cp_req_hdr;
  logic [7:0]  cp_done = '0;
  logic        cp_ack_valid = 1'b0;
  logic [2:0]  cp_ack_ch = '0;
  logic [7:0]  cp_ack_hdr = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  doorbell_mbox uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .cp_req_pending(cp_req_pending), .cp_req_hdr(cp_req_hdr), .cp_done(cp_done),
    .cp_ack_valid(cp_ack_valid), .cp_ack_ch(cp_ack_ch), .cp_ack_hdr(cp_ack_hdr)
  );

  // behavioural reference
  bit [7:0] m_pend, m_stat;
  bit [7:0] m_rq [8];
  bit [7:0] m_ak [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_stat = 0;
      for (int i = 0; i < 8; i++) begin m_rq[i] = 0; m_ak[i] = 0; end
    end else begin
      bit [7:0] s, c, r;
      s = (host_we && host_addr == 5'h00) ? host_wdata[7:0] : 8'h00;
      c = (host_we && host_addr == 5'h03) ? host_wdata[7:0] : 8'h00;
      r = cp_ack_valid ? (8'h01 << cp_ack_ch) : 8'h00;
      m_pend = (m_pend & ~cp_done) | s;
      m_stat = (m_stat & ~c) | r;
      if (host_we && host_addr >= 5'h10 && host_addr <= 5'h17) m_rq[host_addr - 5'h10] = host_wdata[7:0];
      if (cp_ack_valid) m_ak[cp_ack_ch] = cp_ack_hdr;
    end
  end

  function automatic bit [31:0] model_read(input bit [4:0] a);
    if (a == 5'h00 || a == 5'h01) return {24'h0, m_pend};
    if (a == 5'h02) return {24'h0, m_stat};
    if (a >= 5'h10 && a <= 5'h17) return {24'h0, m_rq[a - 5'h10]};
    if (a >= 5'h18) return {24'h0, m_ak[a - 5'h18]};
    return 32'h0;
  endfunction

  function automatic string read_tag(input bit [4:0] a);
    if (a <= 5'h01) return "R4";
    if (a == 5'h02) return "R6";
    if (a >= 5'h10 && a <= 5'h17) return "R5";
    if (a >= 5'h18) return "R6";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // per-cycle comparison, 1 ns after the driving edge
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      bit [63:0] eh;
      for (int i = 0; i < 8; i++) eh[8*i +: 8] = m_rq[i];
      check("R8 irq", {63'h0, host_irq}, {63'h0, (m_stat != 0)});
      check("R2 pending", {56'h0, cp_req_pending}, {56'h0, m_pend});
      check("R5 req_hdr", cp_req_hdr, eh);
      check(read_tag(host_addr), {32'h0, host_rdata}, {32'h0, model_read(host_addr)});
    end
  end

  task automatic drive(input bit we, input bit [4:0] a, input bit [31:0] d,
                       input bit [7:0] dn, input bit av, input bit [2:0] ach, input bit [7:0] ah);
    host_we = we; host_addr = a; host_wdata = d;
    cp_done = dn; cp_ack_valid = av; cp_ack_ch = ach; cp_ack_hdr = ah;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 5'h1F, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_rd(input bit [4:0] a, input bit [31:0] exp, input string tag);
    host_we = 0; host_addr = a; host_wdata = 0;
    cp_done = 0; cp_ack_valid = 0;
    #1;
    check(tag, {32'h0, host_rdata}, {32'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    #250000;
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    expect_rd(5'h01, 0, "R1 pending");
    expect_rd(5'h02, 0, "R1 status");
    expect_rd(5'h13, 0, "R1 req header");
    expect_rd(5'h1C, 0, "R1 ack header");
    check("R1 irq", {63'h0, host_irq}, 64'h0);
    // start-up clear of all acknowledge bits (R7)
    drive(1, 5'h03, 32'hFF, 0, 0, 0, 0);
    // R2: set only affects the ones
    drive(1, 5'h00, 32'h05, 0, 0, 0, 0);
    expect_rd(5'h01, 32'h05, "R2 set 0x05");
    drive(1, 5'h00, 32'h00, 0, 0, 0, 0);
    expect_rd(5'h01, 32'h05, "R2 zero write");
    drive(1, 5'h00, 32'h80, 0, 0, 0, 0);
    expect_rd(5'h00, 32'h85, "R4 set index read");
    // R3: done clears, collision keeps set
    drive(0, 5'h1F, 0, 8'h01, 0, 0, 0);
    expect_rd(5'h01, 32'h84, "R3 done clears");
    drive(1, 5'h00, 32'h04, 8'h04, 0, 0, 0);
    expect_rd(5'h01, 32'h84, "R3 set beats done");
    drive(0, 5'h1F, 0, 8'h84, 0, 0, 0);
    expect_rd(5'h01, 32'h00, "R3 done all");
    // R5: request header
    drive(1, 5'h13, 32'h1A5, 0, 0, 0, 0);
    expect_rd(5'h13, 32'hA5, "R5 header byte");
    check("R5 header bus", {56'h0, cp_req_hdr[31:24]}, 64'hA5);
    // R6 / R8: raise
    drive(0, 5'h1F, 0, 0, 1, 3'd5, 8'h3C);
    expect_rd(5'h02, 32'h20, "R6 status");
    expect_rd(5'h1D, 32'h3C, "R6 ack header");
    check("R8 irq high", {63'h0, host_irq}, 64'h1);
    // R7: upper bits ignored, raise beats clear, clear works
    drive(1, 5'h03, 32'hFFFF_FF00, 0, 0, 0, 0);
    expect_rd(5'h02, 32'h20, "R7 upper bits ignored");
    drive(1, 5'h03, 32'h20, 0, 1, 3'd5, 8'h3D);
    expect_rd(5'h02, 32'h20, "R7 raise beats clear");
    drive(1, 5'h03, 32'h20, 0, 0, 0, 0);
    expect_rd(5'h02, 32'h00, "R7 clear");
    check("R8 irq low", {63'h0, host_irq}, 64'h0);
    // R9: read-only indices
    drive(1, 5'h1D, 32'hFF, 0, 0, 0, 0);
    expect_rd(5'h1D, 32'h3D, "R9 ack header write ignored");
    drive(1, 5'h02, 32'hFF, 0, 0, 0, 0);
    expect_rd(5'h02, 32'h00, "R9 status write ignored");
    drive(1, 5'h01, 32'hFF, 0, 0, 0, 0);
    expect_rd(5'h01, 32'h00, "R9 value write ignored");
    // R10: unmapped
    expect_rd(5'h07, 0, "R10 unmapped 0x07");
    expect_rd(5'h0A, 0, "R10 unmapped 0x0A");
    // random traffic, compared every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      bit [4:0] a;
      bit [3:0] pick;
      pick = 4'($urandom_range(0, 9));
      case (pick)
        0, 1: a = 5'h00;
        2: a = 5'h03;
        3: a = 5'h10 + 5'($urandom_range(0, 7));
        4: a = 5'h18 + 5'($urandom_range(0, 7));
        default: a = 5'($urandom);
      endcase
      drive(1'($urandom), a, $urandom, 8'($urandom) & 8'($urandom),
            ($urandom_range(0, 3) == 0), 3'($urandom), 8'($urandom));
    end
    idle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule